// File: doc/BRIEF.md
# Boot Remap Control Register

This block is the control register of a processor module together with the decode that steers its low boot window. Software writes it through a plain register write port and reads it back as one word. Three bits are stored: byte order (big endian when set), the boot remap enable and an LED enable. One bit reports whether the module sits on a base board, and a strobe bit makes the block emit a one-cycle reset pulse.

The decode sorts every incoming address. An address in the low window (bytes 0 to 0x3FFFF by default) goes to boot ROM or to flash, depending on an external boot switch. Once remap is on and the module is fitted on a board, the same window goes to SRAM. The remap bit has no effect while the active-low fitted input is high. Addresses above the window get a pass-through code. The fitted input passes through a configurable synchronizer before both the read-back and the decode use it.

Top module: `boot_remap_ctl`

## Requirements
- R1: After reset, remap, endian and LED are 0, soft_rst is 0, and every read-back bit other than bit 1 is 0.
- R2: Bit 5 is read/write and drives endian_big (1 = big endian).
- R3: Bit 0 is read/write and drives led_on (1 = lit).
- R4: Bit 2 holds the remap enable; it is read/write and reads back the value last written.
- R5: Writing 1 to bit 3 raises soft_rst for exactly the one cycle after the write edge; bit 3 always reads 0.
- R6: Bits 31:6 and bit 4 always read 0, whatever is written to them.
- R7: Bit 1 reads the level of mod_det_n, SYNC_STAGES cycles after that input changes; writes to bit 1 are ignored.
- R8: An address below WIN_BYTES with effective remap 0 gives tgt_sel 0 (boot ROM) when boot_sw is 1 and 1 (flash) when boot_sw is 0.
- R9: An address below WIN_BYTES with remap 1 and mod_det_n 0 gives tgt_sel 2 (SRAM).
- R10: With mod_det_n 1, the window decodes as if remap were 0, whatever bit 2 holds.
- R11: An address at or above WIN_BYTES gives tgt_sel 3 in every state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | asynchronous active-low reset |
| wr_en | input | 1 | write strobe for the control word |
| wdata | input | DATA_W | write data |
| rdata | output | DATA_W | control word read-back (combinational) |
| mod_det_n | input | 1 | board presence, low when fitted |
| boot_sw | input | 1 | boot select switch, 1 selects ROM |
| addr | input | ADDR_W | access address to classify |
| tgt_sel | output | 2 | 0 ROM, 1 flash, 2 SRAM, 3 other |
| soft_rst | output | 1 | one-cycle reset pulse |
| endian_big | output | 1 | byte order control |
| led_on | output | 1 | LED drive |

## Verification
A write lands on the clock edge where wr_en is high, so rdata, the bit outputs and tgt_sel are due right after that edge, and the bench reads them at the next falling edge. soft_rst is high from that edge until the following one, so the bench samples it high at the first falling edge and low at the second. Changes to boot_sw or addr reach tgt_sel with no register in the path and are checked half a cycle later. A change on mod_det_n passes through SYNC_STAGES flops before it reaches either the read-back or the decode, so the bench waits SYNC_STAGES+1 cycles before it samples.

// File: rtl/boot_remap_pkg.sv
package boot_remap_pkg;

   typedef enum logic [1:0] {
      TGT_ROM   = 2'd0,
      TGT_FLASH = 2'd1,
      TGT_SRAM  = 2'd2,
      TGT_OTHER = 2'd3
   } tgt_e;

   // bit positions in the control word (software visible)
   localparam int unsigned BIT_LED    = 0;
   localparam int unsigned BIT_DET    = 1;
   localparam int unsigned BIT_REMAP  = 2;
   localparam int unsigned BIT_SRST   = 3;
   localparam int unsigned BIT_ENDIAN = 5;
   localparam int unsigned USED_BITS  = 6;

   typedef struct packed {
      logic endian_big;
      logic remap;
      logic led;
   } ctl_s;

endpackage

// File: rtl/brc_det_sync.sv
module brc_det_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic det_n_in,
   output logic det_n_out
);
   generate
      if (STAGES == 0) begin : g_direct
         assign det_n_out = det_n_in;
      end else begin : g_sync
         logic [STAGES-1:0] chain;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               chain <= '1;
            end else if (STAGES == 1) begin
               chain[0] <= det_n_in;
            end else begin
               chain <= {chain[STAGES-2:0], det_n_in};
            end
         end
         assign det_n_out = chain[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/brc_ctl_reg.sv
module brc_ctl_reg
   import boot_remap_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic wr_en,
   input  logic wr_endian,
   input  logic wr_remap,
   input  logic wr_led,
   input  logic wr_srst,
   output ctl_s ctl_q,
   output logic srst_pulse
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl_q      <= '0;
         srst_pulse <= 1'b0;
      end else begin
         srst_pulse <= wr_en & wr_srst;
         if (wr_en) begin
            ctl_q.endian_big <= wr_endian;
            ctl_q.remap      <= wr_remap;
            ctl_q.led        <= wr_led;
         end
      end
   end
endmodule

// File: rtl/brc_readback.sv
module brc_readback
   import boot_remap_pkg::*;
#(
   parameter int unsigned DATA_W = 32
) (
   input  ctl_s              ctl_q,
   input  logic              det_n,
   output logic [DATA_W-1:0] rdata
);
   logic [USED_BITS-1:0] low_bits;

   always_comb begin
      low_bits             = '0;
      low_bits[BIT_LED]    = ctl_q.led;
      low_bits[BIT_DET]    = det_n;
      low_bits[BIT_REMAP]  = ctl_q.remap;
      low_bits[BIT_ENDIAN] = ctl_q.endian_big;
   end

   generate
      if (DATA_W > USED_BITS) begin : g_pad
         assign rdata = {{(DATA_W-USED_BITS){1'b0}}, low_bits};
      end else begin : g_exact
         assign rdata = low_bits;
      end
   endgenerate
endmodule

// File: rtl/brc_window_decode.sv
module brc_window_decode
   import boot_remap_pkg::*;
#(
   parameter int unsigned ADDR_W    = 32,
   parameter int unsigned WIN_BYTES = 32'h0004_0000
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic              remap,
   input  logic              det_n,
   input  logic              boot_sw,
   output tgt_e              tgt
);
   localparam int unsigned WIN_BITS = $clog2(WIN_BYTES);

   logic in_win;
   logic remap_eff;

   generate
      if (WIN_BITS >= ADDR_W) begin : g_all
         assign in_win = 1'b1;
      end else begin : g_part
         assign in_win = (addr[ADDR_W-1:WIN_BITS] == '0);
      end
   endgenerate

   assign remap_eff = remap & ~det_n;

   always_comb begin
      if (!in_win)        tgt = TGT_OTHER;
      else if (remap_eff) tgt = TGT_SRAM;
      else if (boot_sw)   tgt = TGT_ROM;
      else                tgt = TGT_FLASH;
   end
endmodule

// File: rtl/boot_remap_ctl.sv
module boot_remap_ctl
   import boot_remap_pkg::*;
#(
   parameter int unsigned DATA_W      = 32,
   parameter int unsigned ADDR_W      = 32,
   parameter int unsigned WIN_BYTES   = 32'h0004_0000,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   input  logic              mod_det_n,
   input  logic              boot_sw,
   input  logic [ADDR_W-1:0] addr,
   output logic [1:0]        tgt_sel,
   output logic              soft_rst,
   output logic              endian_big,
   output logic              led_on
);
   generate
      if (DATA_W < USED_BITS) begin : g_chk_dw
         $error("DATA_W must cover the control bits");
      end
      if ((WIN_BYTES & (WIN_BYTES - 1)) != 0 || WIN_BYTES == 0) begin : g_chk_win
         $error("WIN_BYTES must be a power of two");
      end
      if ($clog2(WIN_BYTES) > ADDR_W) begin : g_chk_aw
         $error("window exceeds address space");
      end
   endgenerate

   ctl_s ctl_q;
   logic det_n_s;
   tgt_e tgt;

   brc_det_sync #(.STAGES(SYNC_STAGES)) sync_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .det_n_in  (mod_det_n),
      .det_n_out (det_n_s)
   );

   brc_ctl_reg reg_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (wr_en),
      .wr_endian  (wdata[BIT_ENDIAN]),
      .wr_remap   (wdata[BIT_REMAP]),
      .wr_led     (wdata[BIT_LED]),
      .wr_srst    (wdata[BIT_SRST]),
      .ctl_q      (ctl_q),
      .srst_pulse (soft_rst)
   );

   brc_readback #(.DATA_W(DATA_W)) rb_i (
      .ctl_q (ctl_q),
      .det_n (det_n_s),
      .rdata (rdata)
   );

   brc_window_decode #(.ADDR_W(ADDR_W), .WIN_BYTES(WIN_BYTES)) dec_i (
      .addr    (addr),
      .remap   (ctl_q.remap),
      .det_n   (det_n_s),
      .boot_sw (boot_sw),
      .tgt     (tgt)
   );

   assign tgt_sel    = tgt;
   assign endian_big = ctl_q.endian_big;
   assign led_on     = ctl_q.led;
endmodule

// File: rtl/brc_checker.sv
module brc_checker #(
   parameter int unsigned DATA_W    = 32,
   parameter int unsigned ADDR_W    = 32,
   parameter int unsigned WIN_BYTES = 32'h0004_0000
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic              wr_srst,
   input logic              wr_remap,
   input logic [DATA_W-1:0] rdata,
   input logic              boot_sw,
   input logic [ADDR_W-1:0] addr,
   input logic [1:0]        tgt_sel,
   input logic              soft_rst
);
   localparam logic [ADDR_W:0] WIN_LIM = (ADDR_W+1)'(WIN_BYTES);
   logic in_win;
   assign in_win = ({1'b0, addr} < WIN_LIM);

   // R5: a pulse only follows a strobe write
   p_pulse_src_r5: assert property (@(posedge clk) disable iff (!rst_n)
      soft_rst |-> $past(wr_en && wr_srst));
   // R5: strobe bit never reads back
   p_srst_reads0_r5: assert property (@(posedge clk) disable iff (!rst_n)
      rdata[3] == 1'b0);
   // R6: reserved bits read zero
   p_rsv_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (rdata[DATA_W-1:6] == '0) && (rdata[4] == 1'b0));
   // R4: remap bit follows a write
   p_remap_wr_r4: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> (rdata[2] == $past(wr_remap)));
   // R9 / R10: SRAM only with remap set and module fitted
   p_sram_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (tgt_sel == 2'd2) |-> (rdata[2] && !rdata[1]));
   // R8: unremapped window honours the switch
   p_boot_sel_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (in_win && !rdata[2]) |-> (tgt_sel == (boot_sw ? 2'd0 : 2'd1)));
   // R11: outside the window is pass-through
   p_outside_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !in_win |-> (tgt_sel == 2'd3));
endmodule

bind boot_remap_ctl brc_checker #(
   .DATA_W(DATA_W), .ADDR_W(ADDR_W), .WIN_BYTES(WIN_BYTES)
) chk_i (
   .clk      (clk),
   .rst_n    (rst_n),
   .wr_en    (wr_en),
   .wr_srst  (wdata[3]),
   .wr_remap (wdata[2]),
   .rdata    (rdata),
   .boot_sw  (boot_sw),
   .addr     (addr),
   .tgt_sel  (tgt_sel),
   .soft_rst (soft_rst)
);

// File: tb/boot_remap_ctl_tb_top.sv
module boot_remap_ctl_tb_top;
   localparam int unsigned DW = 32;
   localparam int unsigned AW = 32;
   localparam int unsigned WIN = 32'h0004_0000;
   localparam int unsigned SYNC = 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_en = 1'b0;
   logic [DW-1:0] wdata = '0;
   logic [DW-1:0] rdata;
   logic          mod_det_n = 1'b0;
   logic          boot_sw = 1'b0;
   logic [AW-1:0] addr = '0;
   logic [1:0]    tgt_sel;
   logic          soft_rst;
   logic          endian_big;
   logic          led_on;

   int total = 0;
   int bad = 0;
   int cyc = 0;
   logic cur_remap = 1'b0;

   always #10 clk = ~clk;   // 50 MHz

   boot_remap_ctl #(.DATA_W(DW), .ADDR_W(AW), .WIN_BYTES(WIN), .SYNC_STAGES(SYNC)) dut_i (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wdata(wdata), .rdata(rdata),
      .mod_det_n(mod_det_n), .boot_sw(boot_sw), .addr(addr), .tgt_sel(tgt_sel),
      .soft_rst(soft_rst), .endian_big(endian_big), .led_on(led_on)
   );

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc == 150000) begin
         total++; bad++;
         $display("FAIL watchdog: act=hung exp=done");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: act=%h exp=%h", req, act, exp);
      end
   endtask

   function automatic logic [1:0] exp_tgt(input logic [31:0] a, input logic rm,
                                          input logic det, input logic sw);
      if (a >= WIN) return 2'd3;
      if (rm && !det) return 2'd2;
      return sw ? 2'd0 : 2'd1;
   endfunction

   // write; on return the edge has passed and it is the next negedge
   task automatic do_write(input logic [31:0] v);
      @(negedge clk);
      wr_en = 1'b1; wdata = v;
      @(negedge clk);
      wr_en = 1'b0; wdata = '0;
      cur_remap = v[2];
   endtask

   task automatic set_det(input logic d);
      mod_det_n = d;
      repeat (SYNC + 1) @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      repeat (SYNC + 1) @(negedge clk);
      // R1 reset state (fitted, so bit 1 reads 0)
      chk("R1 rdata", rdata, 32'h0);
      chk("R1 soft_rst", {31'b0, soft_rst}, 32'h0);
      chk("R1 endian/led", {30'b0, endian_big, led_on}, 32'h0);
      addr = 32'h0; boot_sw = 1'b1;
      #1 chk("R1 remap off tgt", {30'b0, tgt_sel}, 32'h0);

      // R2 R3 R4 R6 R7 R5: all combinations of the low six bits, junk above
      for (int det = 0; det < 2; det++) begin
         set_det(det[0]);
         for (int v = 0; v < 64; v++) begin
            logic [31:0] w;
            logic [31:0] e;
            w = {26'h2A5_5A5A ^ 26'(v * 7), v[5:0]};
            e = (w & 32'h25) | (32'(det) << 1);
            do_write(w);
            chk("R6 R7 R4 readback", rdata, e);
            chk("R2 endian_big", {31'b0, endian_big}, {31'b0, w[5]});
            chk("R3 led_on", {31'b0, led_on}, {31'b0, w[0]});
            chk("R5 pulse high", {31'b0, soft_rst}, {31'b0, w[3]});
            @(negedge clk);
            chk("R5 pulse one cycle", {31'b0, soft_rst}, 32'h0);
         end
      end

      // R7 presence follows input after the synchronizer
      set_det(1'b0);
      chk("R7 fitted reads 0", {31'b0, rdata[1]}, 32'h0);
      set_det(1'b1);
      chk("R7 unfitted reads 1", {31'b0, rdata[1]}, 32'h1);

      // R8 R9 R10 R11 decode sweep
      for (int rm = 0; rm < 2; rm++) begin
         do_write(32'(rm) << 2);
         for (int det = 0; det < 2; det++) begin
            set_det(det[0]);
            for (int sw = 0; sw < 2; sw++) begin
               for (int k = 0; k < 8; k++) begin
                  logic [31:0] a;
                  case (k)
                     0: a = 32'h0;
                     1: a = 32'h0002_0000;
                     2: a = 32'h0003_FFFC;
                     3: a = 32'h0003_FFFF;
                     4: a = 32'h0004_0000;
                     5: a = 32'h1234_5678;
                     6: a = 32'hFFFF_FFFF;
                     default: a = 32'h8000_0000;
                  endcase
                  @(negedge clk);
                  addr = a; boot_sw = sw[0];
                  #1;
                  if (a >= WIN)
                     chk("R11 outside", {30'b0, tgt_sel}, {30'b0, exp_tgt(a, cur_remap, det[0], sw[0])});
                  else if (cur_remap && !det[0])
                     chk("R9 sram", {30'b0, tgt_sel}, {30'b0, exp_tgt(a, cur_remap, det[0], sw[0])});
                  else if (cur_remap)
                     chk("R10 remap masked", {30'b0, tgt_sel}, {30'b0, exp_tgt(a, cur_remap, det[0], sw[0])});
                  else
                     chk("R8 boot select", {30'b0, tgt_sel}, {30'b0, exp_tgt(a, cur_remap, det[0], sw[0])});
               end
            end
         end
      end

      // R4 remap bit survives presence toggle; R10 returns to SRAM when refitted
      do_write(32'h4);
      set_det(1'b1);
      addr = 32'h100;
      #1 chk("R10 unfitted flash/rom", {30'b0, tgt_sel}, {30'b0, exp_tgt(32'h100, 1'b1, 1'b1, boot_sw)});
      chk("R4 remap held", {31'b0, rdata[2]}, 32'h1);
      set_det(1'b0);
      chk("R9 refitted sram", {30'b0, tgt_sel}, 32'h2);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule